// File: doc/BRIEF.md
# Byte-Port Network Interface

This block is a register-mapped network device that a processor drives one byte at a time over a simple 32-bit register bus. On the line side, a received frame arrives as a start marker with a byte length, followed by a stream of bytes. The block stores these bytes in an internal buffer. Software then empties the buffer through a one-byte read port. For transmission, software programs a byte count and then writes that many bytes to a one-byte write port. Each byte is emitted at once on a transmit stream output, and the final byte of the frame is flagged.

The block has a status flag, a count register for each direction, and an interrupt control register. Completion bits in that register are cleared by writing 1 to them. A software test bit also lives there: it is set by writing 1 and dropped by writing 0 or by reading the register. While the receive-done bit is set, the device accepts no further frame.

Two small state machines sequence the directions. The receive side moves RX_IDLE -> RX_FILL when a frame is accepted, RX_FILL -> RX_DRAIN once all announced bytes are stored, and RX_DRAIN -> RX_IDLE once the count reads zero. The transmit side moves TX_IDLE -> TX_SEND on a valid count write, and TX_SEND -> TX_IDLE on the byte write that brings the count to zero.

Top module: `bytenet_regif`

## Requirements
- R1: Bus word offsets are fixed as follows.
  - 0x00 and 0x04 return the low and high halves of the 64-bit signature for the ASCII text "BYTENET1", with its first character in bits 7:0 of 0x00.
  - 0x18 returns the parameter INFO_WORD.
  - Any unmapped offset below 0x40 returns zero.
- R2: The busy word at 0x08 reads 1 while a frame is being filled or a transmit count is nonzero. Otherwise it reads 0.
- R3: When rx_sof_i is high in a cycle where rx_ready_o is high, the length on rx_len_i is taken. Bytes then enter on rx_valid_i. One cycle after the last announced byte, the receive count at 0x0C holds the length and interrupt control bit 1 is set.
- R4: A read of 0x1C while the receive count is nonzero returns the next stored byte in bits 7:0, with bits 31:8 zero, and lowers the count by one. A read while the count is zero returns zero and changes nothing.
- R5: rx_ready_o is low while interrupt control bit 1 is set, while a frame is filling, or while the receive count is nonzero. A start marker given while rx_ready_o is low is dropped along with its bytes.
- R6: A write to 0x10 loads the transmit count only when the count is zero and the value is between 1 and 65536. Any other write is ignored.
- R7: Each write to 0x20 while the transmit count is nonzero does three things on the next cycle: it emits bits 7:0 of the write data on tx_byte_o with tx_valid_o high for one cycle, it lowers the count by one, and it raises tx_last_o with the byte that takes the count to zero. A write to 0x20 while the count is zero emits nothing.
- R8: The byte write that takes the transmit count to zero sets interrupt control bit 0.
- R9: A write to interrupt control at 0x14 clears bit 0 or bit 1 wherever the write data has a 1, and loads bit 31 from write data bit 31. If a completion event and a clearing write fall in the same cycle, the set wins.
- R10: A read of 0x14 returns the current value, and bit 31 is cleared afterwards.
- R11: irq_o is high exactly when any of interrupt control bits 0, 1 or 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte offset into the 0x40 window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request |
| rx_sof_i | input | 1 | Start of received frame |
| rx_len_i | input | CNT_W | Byte length of received frame |
| rx_ready_o | output | 1 | A new frame would be accepted |
| rx_valid_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final byte of the transmit frame |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. The bench samples it one time unit after raising the strobe, before the clock edge that applies the read's side effects. A register write takes effect at the edge that ends its strobe. The bench therefore checks count and interrupt state, and the transmit byte outputs that are registered on that same edge, at the next falling edge. A received frame finishes one edge after its last byte, so the frame task waits that one extra cycle before any check of the receive count or bit 1.

// File: rtl/bytenet_pkg.sv
package bytenet_pkg;

    // word index = byte offset / 4
    localparam int WORD_ID_LO  = 0;
    localparam int WORD_ID_HI  = 1;
    localparam int WORD_BUSY   = 2;
    localparam int WORD_RXCNT  = 3;
    localparam int WORD_TXCNT  = 4;
    localparam int WORD_INTCTL = 5;
    localparam int WORD_INFO   = 6;
    localparam int WORD_RXDATA = 7;
    localparam int WORD_TXDATA = 8;

    localparam int BIT_TXDONE = 0;
    localparam int BIT_RXDONE = 1;
    localparam int BIT_TEST   = 31;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_FILL  = 2'd1,
        RX_DRAIN = 2'd2
    } rx_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/bytenet_rx.sv
module bytenet_rx
    import bytenet_pkg::*;
#(
    parameter int CNT_W  = 17,
    parameter int BUF_AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             valid_i,
    input  logic [7:0]       byte_i,
    input  logic             hold_i,
    input  logic             pop_i,
    output logic             ready_o,
    output logic [CNT_W-1:0] count_o,
    output logic [7:0]       byte_o,
    output logic             filling_o,
    output logic             done_o
);
    localparam int DEPTH = 1 << BUF_AW;
    localparam logic [CNT_W-1:0]  CNT_ONE = 1;
    localparam logic [BUF_AW-1:0] PTR_ONE = 1;

    rx_state_e state_q, state_nxt;
    logic [CNT_W-1:0]  len_q, fill_q, count_q;
    logic [BUF_AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [7:0]        mem [DEPTH];
    logic              fill_full;

    assign fill_full = (fill_q == len_q);
    assign ready_o   = (state_q == RX_IDLE) && !hold_i;
    assign done_o    = (state_q == RX_FILL) && fill_full;
    assign filling_o = (state_q == RX_FILL);
    assign count_o   = count_q;
    assign byte_o    = (count_q != '0) ? mem[rd_ptr_q] : 8'h00;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            RX_IDLE:  if (ready_o && sof_i) state_nxt = RX_FILL;
            RX_FILL:  if (fill_full)        state_nxt = RX_DRAIN;
            RX_DRAIN: if (count_q == '0)    state_nxt = RX_IDLE;
            default:                        state_nxt = RX_IDLE;
        endcase
    end

    // counters and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            fill_q   <= '0;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (ready_o && sof_i) begin
                        len_q    <= len_i;
                        fill_q   <= '0;
                        wr_ptr_q <= '0;
                    end
                end
                RX_FILL: begin
                    if (fill_full) begin
                        count_q  <= len_q;
                        rd_ptr_q <= '0;
                    end else if (valid_i) begin
                        fill_q   <= fill_q + CNT_ONE;
                        wr_ptr_q <= wr_ptr_q + PTR_ONE;
                    end
                end
                RX_DRAIN: begin
                    if (pop_i && count_q != '0) begin
                        count_q  <= count_q - CNT_ONE;
                        rd_ptr_q <= rd_ptr_q + PTR_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == RX_FILL && !fill_full && valid_i)
            mem[wr_ptr_q] <= byte_i;
    end

endmodule

// File: rtl/bytenet_tx.sv
module bytenet_tx
    import bytenet_pkg::*;
#(
    parameter int CNT_W   = 17,
    parameter int MAX_CNT = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_i,
    input  logic             byte_wr_i,
    input  logic [31:0]      wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             active_o,
    output logic             done_o,
    output logic             tx_valid_o,
    output logic [7:0]       tx_byte_o,
    output logic             tx_last_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;
    localparam logic [31:0]      CNT_MAX = 32'(MAX_CNT);

    tx_state_e state_q, state_nxt;
    logic [CNT_W-1:0] count_q;
    logic             cnt_ok;

    assign cnt_ok   = (wdata_i != 32'd0) && (wdata_i <= CNT_MAX);
    assign done_o   = (state_q == TX_SEND) && byte_wr_i && (count_q == CNT_ONE);
    assign active_o = (state_q == TX_SEND);
    assign count_o  = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            TX_IDLE: if (cnt_wr_i && cnt_ok) state_nxt = TX_SEND;
            TX_SEND: if (done_o)             state_nxt = TX_IDLE;
            default:                         state_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q    <= '0;
            tx_valid_o <= 1'b0;
            tx_byte_o  <= 8'h00;
            tx_last_o  <= 1'b0;
        end else begin
            tx_valid_o <= 1'b0;
            tx_last_o  <= 1'b0;
            unique case (state_q)
                TX_IDLE: if (cnt_wr_i && cnt_ok) count_q <= wdata_i[CNT_W-1:0];
                TX_SEND: begin
                    if (byte_wr_i) begin
                        count_q    <= count_q - CNT_ONE;
                        tx_valid_o <= 1'b1;
                        tx_byte_o  <= wdata_i[7:0];
                        tx_last_o  <= (count_q == CNT_ONE);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bytenet_irq.sv
module bytenet_irq
    import bytenet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic [31:0] wdata_i,
    input  logic        tx_done_i,
    input  logic        rx_done_i,
    output logic [31:0] ctl_o,
    output logic        rx_pend_o,
    output logic        irq_o
);
    logic tx_q, rx_q, test_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= 1'b0;
            rx_q   <= 1'b0;
            test_q <= 1'b0;
        end else begin
            tx_q <= tx_done_i | (tx_q & ~(wr_i & wdata_i[BIT_TXDONE]));
            rx_q <= rx_done_i | (rx_q & ~(wr_i & wdata_i[BIT_RXDONE]));
            if (wr_i)      test_q <= wdata_i[BIT_TEST];
            else if (rd_i) test_q <= 1'b0;
        end
    end

    always_comb begin
        ctl_o             = 32'd0;
        ctl_o[BIT_TXDONE] = tx_q;
        ctl_o[BIT_RXDONE] = rx_q;
        ctl_o[BIT_TEST]   = test_q;
    end

    assign rx_pend_o = rx_q;
    assign irq_o     = tx_q | rx_q | test_q;

endmodule

// File: rtl/bytenet_regif.sv
module bytenet_regif
    import bytenet_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          CNT_W     = 17,
    parameter int          BUF_AW    = 6,
    parameter int          MAX_CNT   = 65536,
    parameter logic [63:0] SIGNATURE = 64'h3154_454E_4554_5942,
    parameter logic [31:0] INFO_WORD = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    input  logic              rx_sof_i,
    input  logic [CNT_W-1:0]  rx_len_i,
    output logic              rx_ready_o,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_byte_o,
    output logic              tx_last_o
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt;
    logic [7:0]        rx_rbyte;
    logic [31:0]       intctl;
    logic              rx_filling, rx_done, rx_pend;
    logic              tx_active, tx_done;
    logic              sel_rxdata, sel_txdata, sel_txcnt, sel_intctl;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign sel_rxdata = (widx == WIDX_W'(WORD_RXDATA));
    assign sel_txdata = (widx == WIDX_W'(WORD_TXDATA));
    assign sel_txcnt  = (widx == WIDX_W'(WORD_TXCNT));
    assign sel_intctl = (widx == WIDX_W'(WORD_INTCTL));

    bytenet_rx #(.CNT_W(CNT_W), .BUF_AW(BUF_AW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_i     (rx_sof_i),
        .len_i     (rx_len_i),
        .valid_i   (rx_valid_i),
        .byte_i    (rx_byte_i),
        .hold_i    (rx_pend),
        .pop_i     (bus_rd && sel_rxdata),
        .ready_o   (rx_ready_o),
        .count_o   (rx_cnt),
        .byte_o    (rx_rbyte),
        .filling_o (rx_filling),
        .done_o    (rx_done)
    );

    bytenet_tx #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_wr_i   (bus_wr && sel_txcnt),
        .byte_wr_i  (bus_wr && sel_txdata),
        .wdata_i    (bus_wdata),
        .count_o    (tx_cnt),
        .active_o   (tx_active),
        .done_o     (tx_done),
        .tx_valid_o (tx_valid_o),
        .tx_byte_o  (tx_byte_o),
        .tx_last_o  (tx_last_o)
    );

    bytenet_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr && sel_intctl),
        .rd_i      (bus_rd && sel_intctl),
        .wdata_i   (bus_wdata),
        .tx_done_i (tx_done),
        .rx_done_i (rx_done),
        .ctl_o     (intctl),
        .rx_pend_o (rx_pend),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata = 32'd0;
        case (int'(widx))
            WORD_ID_LO:  bus_rdata = SIGNATURE[31:0];
            WORD_ID_HI:  bus_rdata = SIGNATURE[63:32];
            WORD_BUSY:   bus_rdata = {31'd0, rx_filling | tx_active};
            WORD_RXCNT:  bus_rdata = 32'(rx_cnt);
            WORD_TXCNT:  bus_rdata = 32'(tx_cnt);
            WORD_INTCTL: bus_rdata = intctl;
            WORD_INFO:   bus_rdata = INFO_WORD;
            WORD_RXDATA: bus_rdata = {24'd0, rx_rbyte};
            default:     bus_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/bytenet_regif_chk.sv
module bytenet_regif_chk
    import bytenet_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_rdata,
    input logic              rx_ready_o,
    input logic              tx_valid_o,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic              rx_pend,
    input logic              test_bit
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [WIDX_W-1:0] widx;
    assign widx = bus_addr[ADDR_W-1:2];

    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pend |-> !rx_ready_o);  // R5

    AST_RX_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx == WIDX_W'(WORD_RXDATA) && rx_cnt != '0)
        |=> rx_cnt == $past(rx_cnt) - CNT_ONE);  // R4

    AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx == WIDX_W'(WORD_RXDATA) && rx_cnt == '0)
        |-> bus_rdata == 32'd0);  // R4

    AST_TX_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == WIDX_W'(WORD_TXDATA) && tx_cnt != '0)
        |=> (tx_valid_o && tx_cnt == $past(tx_cnt) - CNT_ONE));  // R7

    AST_TX_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == WIDX_W'(WORD_TXDATA) && tx_cnt == '0)
        |=> !tx_valid_o);  // R7

    AST_TEST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && widx == WIDX_W'(WORD_INTCTL))
        |=> !test_bit);  // R10

endmodule

bind bytenet_regif bytenet_regif_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .rx_ready_o (rx_ready_o),
    .tx_valid_o (tx_valid_o),
    .rx_cnt     (rx_cnt),
    .tx_cnt     (tx_cnt),
    .rx_pend    (rx_pend),
    .test_bit   (intctl[31])
);

// File: tb/bytenet_regif_tb.sv
module bytenet_regif_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 17;
    localparam logic [31:0] INFO = 32'h0000_0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_o, rx_ready_o, tx_valid_o, tx_last_o;
    logic              rx_sof = 1'b0, rx_valid = 1'b0;
    logic [CNT_W-1:0]  rx_len = '0;
    logic [7:0]        rx_byte = '0, tx_byte_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytenet_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rx_sof_i(rx_sof), .rx_len_i(rx_len),
        .rx_ready_o(rx_ready_o), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .tx_last_o(tx_last_o)
    );

    // signature "BYTENET1", first character in the low byte
    localparam logic [63:0] SIG = {"1", "T", "E", "N", "E", "T", "Y", "B"};

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 32'h0,        SIG[31:0],    4'd1},  // R1 id low
        '{1'b0, 8'h04, 32'h0,        SIG[63:32],   4'd1},  // R1 id high
        '{1'b0, 8'h18, 32'h0,        INFO,         4'd1},  // R1 info
        '{1'b0, 8'h24, 32'h0,        32'h0,        4'd1},  // R1 unmapped
        '{1'b0, 8'h08, 32'h0,        32'h0,        4'd2},  // R2 idle
        '{1'b0, 8'h0C, 32'h0,        32'h0,        4'd3},  // R3 rx count
        '{1'b1, 8'h10, 32'h10001,    32'h0,        4'd6},  // R6 too large
        '{1'b0, 8'h10, 32'h0,        32'h0,        4'd6},
        '{1'b1, 8'h14, 32'h80000000, 32'h0,        4'd9},  // R9 test set
        '{1'b0, 8'h14, 32'h0,        32'h80000000, 4'd10}, // R10
        '{1'b0, 8'h14, 32'h0,        32'h0,        4'd10}, // R10 read cleared
        '{1'b1, 8'h14, 32'h80000000, 32'h0,        4'd9},
        '{1'b1, 8'h14, 32'h0,        32'h0,        4'd9},  // R9 write 0 clears
        '{1'b0, 8'h14, 32'h0,        32'h0,        4'd9},
        '{1'b1, 8'h10, 32'h10000,    32'h0,        4'd6},  // R6 max accepted
        '{1'b0, 8'h10, 32'h0,        32'h10000,    4'd6},
        '{1'b0, 8'h08, 32'h0,        32'h1,        4'd2},  // R2 tx pending
        '{1'b1, 8'h10, 32'h5,        32'h0,        4'd6},  // R6 ignored when busy
        '{1'b0, 8'h10, 32'h0,        32'h10000,    4'd6}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a[ADDR_W-1:0]; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a[ADDR_W-1:0]; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v === exp, req, v, exp);
    endtask

    task automatic frame(input int n, input logic [31:0] bytes);
        rx_sof = 1'b1; rx_len = CNT_W'(n);
        @(posedge clk); @(negedge clk);
        rx_sof = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_byte = bytes[8*i +: 8];
            @(posedge clk); @(negedge clk);
        end
        rx_valid = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, v);
                chk(v === VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // reset state
        do_reset();
        chk(irq_o === 1'b0, "R11 reset irq", 32'(irq_o), 0);
        chk(rx_ready_o === 1'b1, "R5 reset ready", 32'(rx_ready_o), 1);
        chk(tx_valid_o === 1'b0, "R7 reset tx_valid", 32'(tx_valid_o), 0);
        rd_chk(8'h10, 32'h0, "R6 reset txcnt");

        // receive a three byte frame
        frame(3, 32'h00C3B2A1);
        chk(rx_ready_o === 1'b0, "R5 blocked after frame", 32'(rx_ready_o), 0);
        chk(irq_o === 1'b1, "R11 rx irq", 32'(irq_o), 1);
        rd_chk(8'h0C, 32'd3, "R3 rx count");
        rd_chk(8'h14, 32'h2, "R3 rx done bit");
        rd_chk(8'h1C, 32'hA1, "R4 byte0");
        rd_chk(8'h1C, 32'hB2, "R4 byte1");
        rd_chk(8'h0C, 32'd1, "R4 count step");
        rd_chk(8'h1C, 32'hC3, "R4 byte2");
        rd_chk(8'h1C, 32'h0, "R4 empty read");
        rd_chk(8'h0C, 32'd0, "R4 count unchanged");

        // frame while done bit pending is dropped
        chk(rx_ready_o === 1'b0, "R5 pending holds", 32'(rx_ready_o), 0);
        frame(2, 32'h00006655);
        rd_chk(8'h0C, 32'd0, "R5 dropped frame");
        wr(8'h14, 32'h2);
        chk(irq_o === 1'b0, "R9 rx bit cleared irq", 32'(irq_o), 0);
        chk(rx_ready_o === 1'b1, "R5 ready again", 32'(rx_ready_o), 1);
        frame(1, 32'h0000005A);
        rd_chk(8'h1C, 32'h0000005A, "R4 upper bits zero");
        wr(8'h14, 32'h2);

        // transmit two bytes
        wr(8'h10, 32'd2);
        rd_chk(8'h08, 32'h1, "R2 busy tx");
        wr(8'h20, 32'hFFFFFF11);
        chk(tx_valid_o === 1'b1 && tx_byte_o === 8'h11 && tx_last_o === 1'b0,
            "R7 first byte", {tx_last_o, tx_valid_o, tx_byte_o}, {2'b01, 8'h11});
        rd_chk(8'h10, 32'd1, "R7 count step");
        chk(tx_valid_o === 1'b0, "R7 one cycle valid", 32'(tx_valid_o), 0);
        wr(8'h20, 32'h22);
        chk(tx_valid_o === 1'b1 && tx_byte_o === 8'h22 && tx_last_o === 1'b1,
            "R7 last byte", {tx_last_o, tx_valid_o, tx_byte_o}, {2'b11, 8'h22});
        chk(irq_o === 1'b1, "R11 tx irq", 32'(irq_o), 1);
        rd_chk(8'h14, 32'h1, "R8 tx done bit");
        rd_chk(8'h08, 32'h0, "R2 idle after tx");
        wr(8'h20, 32'h33);
        chk(tx_valid_o === 1'b0, "R7 extra write ignored", 32'(tx_valid_o), 0);
        rd_chk(8'h10, 32'h0, "R7 count stays zero");
        wr(8'h14, 32'h1);
        rd_chk(8'h14, 32'h0, "R9 tx bit cleared");
        chk(irq_o === 1'b0, "R11 irq low", 32'(irq_o), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule